// File: doc/BRIEF.md
# Parallel NOR Flash Command Front End

This block models the command side of a parallel NOR flash. It samples a simple bus on every clock: chip select, output enable and write enable (all active low), an address and a byte of write data. A clock where chip select and write enable are low and output enable is high is one write cycle. A clock where chip select and output enable are low and write enable is high is one read cycle. Write cycles are decoded as multi-cycle unlock sequences. These start an embedded program of one word, or an embedded erase of one sector or of the whole array. The erase first drives every word of its target sectors to zero and then sets them to all ones. The small storage array sits inside the block.

While an operation runs, `ready` is low and reads return a status byte in place of array data. A sector erase can be held so that other sectors can be read and programmed, and then continued. An unlock-bypass mode shortens a program to two writes. Each sector has a lock input that blocks program and erase in that sector. A synchronous abort input ends any operation and returns the block to array reading. Operation lengths are parameters, given in clock cycles.

Top module: `flash_cmd_ctl`

## Requirements
- R1: After reset `ready` is 1 and every array word reads 0xFF.
- R2: `rdata` shows a value only on a read cycle (`ce_n`=0, `oe_n`=0, `we_n`=1); on any other cycle it is 0x00.
- R3: Writes 0xAA@0x555, 0x55@0x2AA, 0xA0@0x555, then D@A start a program. `ready` is low for PROG_CYCLES cycles, starting the cycle after the last write. The word at A then holds old AND D, so a program can only clear bits.
- R4: A read while `ready` is low returns status. Bit 7 is the complement of bit 7 of the data being programmed, or 0 during an erase. Bits 5:0 are 0. Bit 6 starts at 0 after reset and inverts after every status read cycle.
- R5: Writes 0xAA@0x555, 0x55@0x2AA, 0x80@0x555, 0xAA@0x555, 0x55@0x2AA, then 0x30 at any address in sector S start a sector erase (sector = address bits 5:4). `ready` is low for 2^ARR_AW + ERASE_CYCLES cycles. Afterwards all of S reads 0xFF and every other sector is unchanged.
- R6: The same sequence ending in 0x10@0x555 erases every sector whose lock bit is 0.
- R7: 0xAA@0x555, 0x55@0x2AA, 0x20@0x555 enter bypass mode. In bypass, 0xA0 at any address followed by D@A programs. 0x90 then 0x00 leave bypass, after which a lone 0xA0 no longer starts a program.
- R8: With `lock[S]`=1, a program or sector erase aimed at sector S leaves `ready` high and the sector's data unchanged.
- R9: 0xB0 written during an erase makes `ready` 1 from the next cycle. While held, reads of other sectors return array data, and programs to other sectors run normally. A program to the held sector is ignored. 0x30 written while held continues the erase to completion.
- R10: A write that does not fit the sequence in progress (wrong address or code, including 0xF0) returns the decoder to its idle state without starting anything.
- R11: `abort_i`=1 ends any program or erase, cancels a held erase and clears bypass mode; `ready` is 1 on the next cycle.
- R12: Write cycles while `ready` is low, other than 0xB0 during an erase, have no effect on the decoder or the array.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; array returns to all ones |
| abort_i | input | 1 | Synchronous stop of any operation, back to array read |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | ADDR_W | Bus address |
| wdata | input | 8 | Write data |
| lock | input | 2^SECT_AW | Per-sector program/erase lock |
| rdata | output | 8 | Array data or status on a read cycle |
| ready | output | 1 | 1 when no operation holds the array |

## Verification
The bench drives complete four-write and six-write sequences, which must succeed, and truncated or corrupted ones, which must start nothing. Comparing the two separates real sequence tracking from matching on the final code alone. Bypass programs are tried before and after exit, and the same address is programmed twice, so that AND-accumulation is distinguished from overwrite. Erases are run on a sector next to a programmed neighbour, with a locked sector, and with a hold and continue in the middle. Together these show whether the sector mask, the lock filter and the held-erase read path each work on their own. Back-to-back status reads separate a per-read toggle from a per-clock one.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;
  localparam int DW = 8;

  localparam logic [7:0] CMD_UNLK1  = 8'hAA;
  localparam logic [7:0] CMD_UNLK2  = 8'h55;
  localparam logic [7:0] CMD_PROG   = 8'hA0;
  localparam logic [7:0] CMD_ERSET  = 8'h80;
  localparam logic [7:0] CMD_SECT   = 8'h30;
  localparam logic [7:0] CMD_CHIP   = 8'h10;
  localparam logic [7:0] CMD_BYPON  = 8'h20;
  localparam logic [7:0] CMD_BYPX1  = 8'h90;
  localparam logic [7:0] CMD_BYPX2  = 8'h00;
  localparam logic [7:0] CMD_HOLD   = 8'hB0;
  localparam logic [7:0] CMD_CONT   = 8'h30;

  localparam logic [10:0] UNLK_ADR1 = 11'h555;
  localparam logic [10:0] UNLK_ADR2 = 11'h2AA;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_UL1,
    SQ_UL2,
    SQ_PDATA,
    SQ_EUL0,
    SQ_EUL1,
    SQ_EFIN,
    SQ_BXIT
  } seq_t;
endpackage

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              abort_i,
  input  logic              wr_stb,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DW-1:0]     wdata,
  input  logic              busy,
  input  logic              erase_run,
  input  logic              held,
  output logic              go_prog,
  output logic              go_sect,
  output logic              go_chip,
  output logic              go_hold,
  output logic              go_cont
);
  seq_t st_q, st_d;
  logic byp_q, byp_d;
  logic at_a1, at_a2, is_ul1, is_ul2;

  assign at_a1  = (addr[10:0] == UNLK_ADR1);
  assign at_a2  = (addr[10:0] == UNLK_ADR2);
  assign is_ul1 = at_a1 && (wdata == CMD_UNLK1);
  assign is_ul2 = at_a2 && (wdata == CMD_UNLK2);

  always_comb begin
    st_d    = st_q;
    byp_d   = byp_q;
    go_prog = 1'b0;
    go_sect = 1'b0;
    go_chip = 1'b0;
    go_hold = 1'b0;
    go_cont = 1'b0;
    if (busy) begin
      st_d = SQ_IDLE;
      if (wr_stb && erase_run && (wdata == CMD_HOLD)) go_hold = 1'b1;
    end else if (wr_stb) begin
      st_d = SQ_IDLE;
      unique case (st_q)
        SQ_IDLE: begin
          if (byp_q && (wdata == CMD_PROG))       st_d = SQ_PDATA;
          else if (byp_q && (wdata == CMD_BYPX1)) st_d = SQ_BXIT;
          else if (is_ul1)                        st_d = SQ_UL1;
          else if (held && (wdata == CMD_CONT))   go_cont = 1'b1;
        end
        SQ_UL1: if (is_ul2) st_d = SQ_UL2;
        SQ_UL2: begin
          if (at_a1) begin
            if (wdata == CMD_PROG)       st_d = SQ_PDATA;
            else if (wdata == CMD_ERSET) st_d = SQ_EUL0;
            else if (wdata == CMD_BYPON) byp_d = 1'b1;
          end
        end
        SQ_PDATA: go_prog = 1'b1;
        SQ_EUL0:  if (is_ul1) st_d = SQ_EUL1;
        SQ_EUL1:  if (is_ul2) st_d = SQ_EFIN;
        SQ_EFIN: begin
          if (wdata == CMD_SECT)                go_sect = 1'b1;
          else if (at_a1 && wdata == CMD_CHIP)  go_chip = 1'b1;
        end
        SQ_BXIT: if (wdata == CMD_BYPX2) byp_d = 1'b0;
        default: st_d = SQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= SQ_IDLE;
      byp_q <= 1'b0;
    end else if (abort_i) begin
      st_q  <= SQ_IDLE;
      byp_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      byp_q <= byp_d;
    end
  end
endmodule

// File: rtl/flash_cmd_engine.sv
module flash_cmd_engine
  import flash_cmd_pkg::*;
#(
  parameter int ARR_AW       = 6,
  parameter int SECT_AW      = 2,
  parameter int PROG_CYCLES  = 4,
  parameter int ERASE_CYCLES = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      abort_i,
  input  logic                      go_prog,
  input  logic                      go_sect,
  input  logic                      go_chip,
  input  logic                      go_hold,
  input  logic                      go_cont,
  input  logic [ARR_AW-1:0]         op_idx,
  input  logic [DW-1:0]             op_data,
  input  logic [(1<<SECT_AW)-1:0]   lock,
  input  logic [SECT_AW-1:0]        rd_sec,
  output logic                      busy,
  output logic                      erase_run,
  output logic                      held,
  output logic                      stat_sel,
  output logic                      poll_bit,
  output logic                      pg_en,
  output logic [ARR_AW-1:0]         pg_idx,
  output logic [DW-1:0]             pg_val,
  output logic                      er_en,
  output logic [(1<<SECT_AW)-1:0]   er_mask
);
  localparam int NSECT = 1 << SECT_AW;
  localparam int PCW   = (PROG_CYCLES  > 1) ? $clog2(PROG_CYCLES)  : 1;
  localparam int ECW   = (ERASE_CYCLES > 1) ? $clog2(ERASE_CYCLES) : 1;
  localparam logic [ARR_AW-1:0] LAST_IDX = '1;

  logic              prg_q, prg_d;
  logic [PCW-1:0]    pcnt_q, pcnt_d;
  logic [ARR_AW-1:0] pidx_q, pidx_d;
  logic [DW-1:0]     pval_q, pval_d;
  logic              ers_q, ers_d;
  logic              pre_q, pre_d;
  logic [ARR_AW-1:0] eidx_q, eidx_d;
  logic [ECW-1:0]    ecnt_q, ecnt_d;
  logic [NSECT-1:0]  emask_q, emask_d;
  logic              hold_q, hold_d;
  logic [SECT_AW-1:0] op_sec, pre_sec;
  logic [NSECT-1:0]  new_mask;

  assign op_sec   = op_idx[ARR_AW-1 -: SECT_AW];
  assign pre_sec  = eidx_q[ARR_AW-1 -: SECT_AW];
  assign new_mask = (go_chip ? {NSECT{1'b1}} : (NSECT'(1) << op_sec)) & ~lock;

  assign busy      = prg_q | (ers_q & ~hold_q);
  assign erase_run = ers_q & ~hold_q & ~prg_q;
  assign held      = ers_q & hold_q;
  assign stat_sel  = busy | (ers_q & hold_q & emask_q[rd_sec]);
  assign poll_bit  = prg_q & ~pval_q[DW-1];
  assign er_mask   = emask_q;

  always_comb begin
    prg_d   = prg_q;
    pcnt_d  = pcnt_q;
    pidx_d  = pidx_q;
    pval_d  = pval_q;
    ers_d   = ers_q;
    pre_d   = pre_q;
    eidx_d  = eidx_q;
    ecnt_d  = ecnt_q;
    emask_d = emask_q;
    hold_d  = hold_q;
    pg_en   = 1'b0;
    pg_idx  = pidx_q;
    pg_val  = pval_q;
    er_en   = 1'b0;
    if (abort_i) begin
      prg_d  = 1'b0;
      ers_d  = 1'b0;
      hold_d = 1'b0;
    end else begin
      if (prg_q) begin
        if (pcnt_q == '0) begin
          pg_en = 1'b1;
          prg_d = 1'b0;
        end else begin
          pcnt_d = pcnt_q - 1'b1;
        end
      end else if (go_prog && !lock[op_sec] && !(ers_q && emask_q[op_sec])) begin
        prg_d  = 1'b1;
        pcnt_d = PCW'(PROG_CYCLES - 1);
        pidx_d = op_idx;
        pval_d = op_data;
      end

      if (erase_run) begin
        if (go_hold) begin
          hold_d = 1'b1;
        end else if (pre_q) begin
          if (emask_q[pre_sec]) begin
            pg_en  = 1'b1;
            pg_idx = eidx_q;
            pg_val = '0;
          end
          if (eidx_q == LAST_IDX) begin
            pre_d  = 1'b0;
            ecnt_d = ECW'(ERASE_CYCLES - 1);
          end else begin
            eidx_d = eidx_q + 1'b1;
          end
        end else if (ecnt_q == '0) begin
          er_en = 1'b1;
          ers_d = 1'b0;
        end else begin
          ecnt_d = ecnt_q - 1'b1;
        end
      end else if (held && go_cont) begin
        hold_d = 1'b0;
      end else if (!ers_q && !prg_q && (go_sect || go_chip) && (new_mask != '0)) begin
        ers_d   = 1'b1;
        pre_d   = 1'b1;
        eidx_d  = '0;
        emask_d = new_mask;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prg_q   <= 1'b0;
      pcnt_q  <= '0;
      pidx_q  <= '0;
      pval_q  <= '0;
      ers_q   <= 1'b0;
      pre_q   <= 1'b0;
      eidx_q  <= '0;
      ecnt_q  <= '0;
      emask_q <= '0;
      hold_q  <= 1'b0;
    end else begin
      prg_q   <= prg_d;
      pcnt_q  <= pcnt_d;
      pidx_q  <= pidx_d;
      pval_q  <= pval_d;
      ers_q   <= ers_d;
      pre_q   <= pre_d;
      eidx_q  <= eidx_d;
      ecnt_q  <= ecnt_d;
      emask_q <= emask_d;
      hold_q  <= hold_d;
    end
  end
endmodule

// File: rtl/flash_cmd_array.sv
module flash_cmd_array
  import flash_cmd_pkg::*;
#(
  parameter int ARR_AW  = 6,
  parameter int SECT_AW = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    pg_en,
  input  logic [ARR_AW-1:0]       pg_idx,
  input  logic [DW-1:0]           pg_val,
  input  logic                    er_en,
  input  logic [(1<<SECT_AW)-1:0] er_mask,
  input  logic [ARR_AW-1:0]       rd_idx,
  output logic [DW-1:0]           rd_word
);
  localparam int WORDS = 1 << ARR_AW;
  localparam int SWB   = ARR_AW - SECT_AW;

  logic [DW-1:0] mem [WORDS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int w = 0; w < WORDS; w++) mem[w] <= '1;
    end else begin
      for (int w = 0; w < WORDS; w++) begin
        if (er_en && er_mask[w >> SWB]) begin
          mem[w] <= '1;
        end else if (pg_en && (pg_idx == ARR_AW'(w))) begin
          mem[w] <= mem[w] & pg_val;
        end
      end
    end
  end

  assign rd_word = mem[rd_idx];
endmodule

// File: rtl/flash_cmd_ctl.sv
module flash_cmd_ctl
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W       = 11,
  parameter int ARR_AW       = 6,
  parameter int SECT_AW      = 2,
  parameter int PROG_CYCLES  = 4,
  parameter int ERASE_CYCLES = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    abort_i,
  input  logic                    ce_n,
  input  logic                    oe_n,
  input  logic                    we_n,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [7:0]              wdata,
  input  logic [(1<<SECT_AW)-1:0] lock,
  output logic [7:0]              rdata,
  output logic                    ready
);
  localparam int NSECT = 1 << SECT_AW;

  logic rd_act, wr_stb;
  logic busy, erase_run, held, stat_sel, poll_bit;
  logic go_prog, go_sect, go_chip, go_hold, go_cont;
  logic pg_en, er_en;
  logic [ARR_AW-1:0] pg_idx;
  logic [DW-1:0] pg_val, rd_word;
  logic [NSECT-1:0] er_mask;
  logic tog_q;

  assign rd_act = ~ce_n & ~oe_n & we_n;
  assign wr_stb = ~ce_n & ~we_n & oe_n;

  flash_cmd_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .abort_i(abort_i), .wr_stb(wr_stb),
    .addr(addr), .wdata(wdata), .busy(busy), .erase_run(erase_run),
    .held(held), .go_prog(go_prog), .go_sect(go_sect), .go_chip(go_chip),
    .go_hold(go_hold), .go_cont(go_cont)
  );

  flash_cmd_engine #(
    .ARR_AW(ARR_AW), .SECT_AW(SECT_AW),
    .PROG_CYCLES(PROG_CYCLES), .ERASE_CYCLES(ERASE_CYCLES)
  ) u_eng (
    .clk(clk), .rst_n(rst_n), .abort_i(abort_i),
    .go_prog(go_prog), .go_sect(go_sect), .go_chip(go_chip),
    .go_hold(go_hold), .go_cont(go_cont),
    .op_idx(addr[ARR_AW-1:0]), .op_data(wdata), .lock(lock),
    .rd_sec(addr[ARR_AW-1 -: SECT_AW]),
    .busy(busy), .erase_run(erase_run), .held(held), .stat_sel(stat_sel),
    .poll_bit(poll_bit), .pg_en(pg_en), .pg_idx(pg_idx), .pg_val(pg_val),
    .er_en(er_en), .er_mask(er_mask)
  );

  flash_cmd_array #(.ARR_AW(ARR_AW), .SECT_AW(SECT_AW)) u_arr (
    .clk(clk), .rst_n(rst_n), .pg_en(pg_en), .pg_idx(pg_idx),
    .pg_val(pg_val), .er_en(er_en), .er_mask(er_mask),
    .rd_idx(addr[ARR_AW-1:0]), .rd_word(rd_word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tog_q <= 1'b0;
    else if (rd_act && stat_sel) tog_q <= ~tog_q;
  end

  always_comb begin
    if (!rd_act)       rdata = '0;
    else if (stat_sel) rdata = {poll_bit, tog_q, 6'b0};
    else               rdata = rd_word;
  end

  assign ready = ~busy;
endmodule

// File: rtl/flash_cmd_ctl_chk.sv
module flash_cmd_ctl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       abort_i,
  input logic       ce_n,
  input logic       oe_n,
  input logic       we_n,
  input logic [7:0] rdata,
  input logic       ready
);
  logic rd_c, wr_c;
  assign rd_c = !ce_n && !oe_n && we_n;
  assign wr_c = !ce_n && !we_n && oe_n;

  a_r11_abort_ready: assert property (@(posedge clk) disable iff (!rst_n)
    abort_i |=> ready);

  a_r4_toggle_flip: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_c && !ready) |=> (!(rd_c && !ready) || (rdata[6] != $past(rdata[6]))));

  a_r4_status_low_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_c && !ready) |-> (rdata[5:0] == 6'd0));

  a_r2_quiet_bus: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_c |-> (rdata == 8'd0));

  a_r3_busy_from_write: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ready) |-> $past(wr_c));
endmodule

bind flash_cmd_ctl flash_cmd_ctl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .abort_i(abort_i), .ce_n(ce_n), .oe_n(oe_n),
  .we_n(we_n), .rdata(rdata), .ready(ready)
);

// File: tb/flash_cmd_ctl_tb.sv
module flash_cmd_ctl_tb;
  localparam int PC = 4;
  localparam int EC = 8;

  logic clk, rst_n, abort_i, ce_n, oe_n, we_n;
  logic [10:0] addr;
  logic [7:0] wdata, rdata;
  logic [3:0] lock;
  logic ready;

  int checks = 0;
  int errors = 0;
  string cur_req = "R1";
  bit cmp_en = 0;
  logic [7:0] last_rd;
  int n;

  flash_cmd_ctl u_dut (
    .clk(clk), .rst_n(rst_n), .abort_i(abort_i), .ce_n(ce_n), .oe_n(oe_n),
    .we_n(we_n), .addr(addr), .wdata(wdata), .lock(lock),
    .rdata(rdata), .ready(ready)
  );

  initial clk = 0;
  always #4 clk = ~clk;

  // ---------------- behavioural reference ----------------
  int mem [64];
  bit mprog, mer, mpre, mhold, mbyp, mtog;
  int mpcnt, mpidx, mecnt, meidx, mseq;
  int mpval;
  bit [3:0] mmask;

  function automatic int sec_of(int a);
    return (a & 63) / 16;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 64; i++) mem[i] = 255;
      mprog = 0; mer = 0; mpre = 0; mhold = 0; mbyp = 0; mtog = 0;
      mpcnt = 0; mpidx = 0; mecnt = 0; meidx = 0; mseq = 0; mpval = 0; mmask = 0;
    end else begin
      bit rd, wr, bsy, sts;
      int a, d, s, nseq;
      bit [3:0] m;
      rd = !ce_n && !oe_n && we_n;
      wr = !ce_n && !we_n && oe_n;
      a = int'(addr); d = int'(wdata); s = sec_of(a);
      bsy = mprog || (mer && !mhold);
      sts = bsy || (mer && mhold && mmask[s]);
      if (rd && sts) mtog = !mtog;
      if (abort_i) begin
        mprog = 0; mer = 0; mhold = 0; mbyp = 0; mseq = 0;
      end else if (bsy) begin
        mseq = 0;
        if (mprog) begin
          if (mpcnt == 0) begin mem[mpidx] = mem[mpidx] & mpval; mprog = 0; end
          else mpcnt--;
        end else if (wr && d == 'hB0) begin
          mhold = 1;
        end else if (mpre) begin
          if (mmask[meidx / 16]) mem[meidx] = 0;
          if (meidx == 63) begin mpre = 0; mecnt = EC - 1; end
          else meidx++;
        end else if (mecnt == 0) begin
          for (int i = 0; i < 64; i++) if (mmask[i / 16]) mem[i] = 255;
          mer = 0;
        end else mecnt--;
      end else if (wr) begin
        nseq = 0;
        case (mseq)
          0: if (mbyp && d == 'hA0) nseq = 3;
             else if (mbyp && d == 'h90) nseq = 7;
             else if (a == 'h555 && d == 'hAA) nseq = 1;
             else if (mhold && d == 'h30) mhold = 0;
          1: if (a == 'h2AA && d == 'h55) nseq = 2;
          2: if (a == 'h555) begin
               if (d == 'hA0) nseq = 3;
               else if (d == 'h80) nseq = 4;
               else if (d == 'h20) mbyp = 1;
             end
          3: if (!lock[s] && !(mer && mmask[s])) begin
               mprog = 1; mpcnt = PC - 1; mpidx = a & 63; mpval = d;
             end
          4: if (a == 'h555 && d == 'hAA) nseq = 5;
          5: if (a == 'h2AA && d == 'h55) nseq = 6;
          6: if (!mer) begin
               m = 0;
               if (d == 'h30) m = 4'(1 << s) & ~lock;
               else if (d == 'h10 && a == 'h555) m = ~lock;
               if (m != 0) begin mer = 1; mpre = 1; meidx = 0; mmask = m; end
             end
          7: if (d == 0) mbyp = 0;
          default: ;
        endcase
        mseq = nseq;
      end
    end
  end

  always @(negedge clk) begin
    if (cmp_en) begin
      bit rd, sts;
      int exp_rd, exp_rdy;
      rd = !ce_n && !oe_n && we_n;
      exp_rdy = (mprog || (mer && !mhold)) ? 0 : 1;
      sts = !exp_rdy || (mer && mhold && mmask[sec_of(int'(addr))]);
      if (!rd) exp_rd = 0;
      else if (sts) exp_rd = ((mprog && !mpval[7]) ? 128 : 0) + (mtog ? 64 : 0);
      else exp_rd = mem[int'(addr) & 63];
      checks++;
      if (int'(ready) != exp_rdy || int'(rdata) != exp_rd) begin
        errors++;
        $display("FAIL %s model: ready=%0d rdata=%02h expected ready=%0d rdata=%02h",
                 cur_req, ready, rdata, exp_rdy, exp_rd);
      end
    end
  end

  // ---------------- watchdog ----------------
  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc == 100000) begin
      errors++;
      $display("FAIL %s watchdog: actual=%0d cycles expected<%0d", cur_req, cyc, 100000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  // ---------------- tasks ----------------
  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc_drv(bit c, bit o, bit w, int a, int d);
    ce_n = c; oe_n = o; we_n = w; addr = 11'(a); wdata = 8'(d);
    @(negedge clk);
    last_rd = rdata;
    @(posedge clk); #1;
    ce_n = 1; oe_n = 1; we_n = 1;
  endtask

  task automatic wr(int a, int d);
    cyc_drv(0, 1, 0, a, d);
  endtask

  task automatic rd(int a);
    cyc_drv(0, 0, 1, a, 0);
  endtask

  task automatic idle(int k);
    repeat (k) begin @(posedge clk); #1; end
  endtask

  task automatic unlock();
    wr('h555, 'hAA); wr('h2AA, 'h55);
  endtask

  task automatic prog4(int a, int d);
    unlock(); wr('h555, 'hA0); wr(a, d);
  endtask

  task automatic erase_seq(int a, int code);
    unlock(); wr('h555, 'h80); unlock(); wr(a, code);
  endtask

  task automatic wait_ready(output int cnt);
    cnt = 0;
    forever begin
      @(negedge clk);
      if (ready) break;
      cnt++;
    end
    @(posedge clk); #1;
  endtask

  task automatic ready_now(string req, int exp);
    @(negedge clk);
    check(req, int'(ready), exp);
    @(posedge clk); #1;
  endtask

  // ---------------- stimulus ----------------
  initial begin
    logic [7:0] r1, r2;
    rst_n = 0; abort_i = 0; ce_n = 1; oe_n = 1; we_n = 1;
    addr = 0; wdata = 0; lock = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    cmp_en = 1;
    idle(2);

    cur_req = "R1";
    rd(0);  check("R1", last_rd, 'hFF);
    rd(63); check("R1", last_rd, 'hFF);
    ready_now("R1", 1);

    cur_req = "R2";
    cyc_drv(1, 0, 1, 0, 0); check("R2", last_rd, 0);
    cyc_drv(0, 1, 1, 0, 0); check("R2", last_rd, 0);
    cyc_drv(0, 0, 0, 0, 0); check("R2", last_rd, 0);

    cur_req = "R3";
    prog4(5, 'h3C); wait_ready(n); check("R3", n, PC);
    rd(5); check("R3", last_rd, 'h3C);
    prog4(5, 'hF0); wait_ready(n);
    rd(5); check("R3", last_rd, 'h30);

    cur_req = "R4";
    prog4(6, 'h5A);
    rd(6); r1 = last_rd;
    rd(6); r2 = last_rd;
    check("R4", int'(r1[7]), 1);
    check("R4", int'(r1[5:0]), 0);
    check("R4", int'(r1[6] ^ r2[6]), 1);
    wait_ready(n);
    rd(6); check("R4", last_rd, 'h5A);

    cur_req = "R10";
    unlock(); wr('h555, 'h77); wr('h555, 'hA0); wr(7, 0);
    ready_now("R10", 1);
    rd(7); check("R10", last_rd, 'hFF);
    unlock(); wr(0, 'hF0); wr('h555, 'hA0); wr(8, 0);
    ready_now("R10", 1);
    rd(8); check("R10", last_rd, 'hFF);

    cur_req = "R7";
    unlock(); wr('h555, 'h20);
    wr(0, 'hA0); wr(9, 'h11); wait_ready(n); check("R7", n, PC);
    rd(9); check("R7", last_rd, 'h11);
    wr(0, 'h90); wr(0, 0);
    wr(0, 'hA0); wr(10, 0);
    ready_now("R7", 1);
    rd(10); check("R7", last_rd, 'hFF);

    cur_req = "R5";
    prog4(34, 'h12); wait_ready(n);
    erase_seq(5, 'h30); wait_ready(n); check("R5", n, 64 + EC);
    rd(5);  check("R5", last_rd, 'hFF);
    rd(6);  check("R5", last_rd, 'hFF);
    rd(34); check("R5", last_rd, 'h12);

    cur_req = "R8";
    lock = 4'b0100;
    prog4(35, 0);
    ready_now("R8", 1);
    rd(35); check("R8", last_rd, 'hFF);
    erase_seq(34, 'h30);
    ready_now("R8", 1);
    rd(34); check("R8", last_rd, 'h12);

    cur_req = "R6";
    prog4(50, 'hAB); wait_ready(n);
    prog4(1, 'hCD);  wait_ready(n);
    erase_seq('h555, 'h10); wait_ready(n); check("R6", n, 64 + EC);
    rd(50); check("R6", last_rd, 'hFF);
    rd(1);  check("R6", last_rd, 'hFF);
    rd(34); check("R6", last_rd, 'h12);
    lock = 0;

    cur_req = "R9";
    prog4(17, 'h77); wait_ready(n);
    erase_seq(48, 'h30);
    idle(10);
    wr(0, 'hB0);
    ready_now("R9", 1);
    rd(17); check("R9", last_rd, 'h77);
    prog4(20, 'h0F); wait_ready(n); check("R9", n, PC);
    rd(20); check("R9", last_rd, 'h0F);
    prog4(49, 0);
    ready_now("R9", 1);
    wr(0, 'h30);
    wait_ready(n);
    check("R9", int'(n > 0 && n < 64 + EC), 1);
    rd(48); check("R9", last_rd, 'hFF);
    rd(49); check("R9", last_rd, 'hFF);
    rd(20); check("R9", last_rd, 'h0F);

    cur_req = "R12";
    prog4(40, 'hF0);
    wr('h555, 'hAA); wr('h2AA, 'h55);
    wait_ready(n);
    wr('h555, 'hA0); wr(41, 0);
    ready_now("R12", 1);
    rd(41); check("R12", last_rd, 'hFF);

    cur_req = "R11";
    unlock(); wr('h555, 'h20);
    erase_seq('h555, 'h10);
    idle(5);
    abort_i = 1; idle(1); abort_i = 0;
    ready_now("R11", 1);
    wr(0, 'hA0); wr(11, 0);
    ready_now("R11", 1);
    rd(11); check("R11", last_rd, 'hFF);
    rd(0);  check("R11", last_rd, 0);

    idle(3);
    cmp_en = 0;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule